// File: doc/BRIEF.md
# OSD Pixel Decoder and Blender

This block turns an on-screen-display byte stream, already fetched from memory, into a stream of palette indices. It then looks each index up in a palette. Every palette entry holds a 4-bit opacity and a pixel value. The looked-up pixel is mixed over an incoming video pixel stream. The source data may be packed bitmaps at 1, 2, 4 or 8 bits per pixel, or run-length pairs for 16-colour or 256-colour palettes. In warp mode, one programmable byte value inside bitmap data introduces a run. In the 1-bit mode, the block can draw an automatic outline around foreground pixels.

The video stream sets the pace. Each accepted video pixel yields exactly one mixed output pixel on the next cycle. Bytes are pulled from the input only as fast as pixels are consumed. A line-width parameter gives the decoder a column position. That position is used for end-of-line padding and to keep the outline from crossing line boundaries.

The byte unpacker is a state machine with these states:
- **G_BYTE**: waits for a bitmap byte, or for a count in run-length formats.
- **G_WCNT**: waits for the count byte that follows a warp code.
- **G_IDX**: waits for the colour byte of a run.
- **G_BITS**: emits the pixels of one unpacked byte.
- **G_RUN**: emits a run.
- **G_PAD**: fills the rest of a line with index 0.

The transitions are:
- G_BYTE to G_BITS on an ordinary bitmap byte.
- G_BYTE to G_WCNT on a warp code.
- G_BYTE or G_WCNT to G_IDX on a non-zero count.
- G_BYTE or G_WCNT to G_PAD on a zero count taken mid-line.
- G_WCNT to G_BYTE on a zero count taken at column 0.
- G_IDX to G_RUN on the colour byte.
- G_BITS, G_RUN and G_PAD back to G_BYTE after their last pixel.

Top module: `osd_pixel_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `vid_ready` is 0.
- R2: The format codes 0, 1, 2 and 3 select bitmaps of 1, 2, 4 and 8 bits per pixel. All pixels of a byte are emitted, starting with the most significant field.
- R3: Format code 4 (16-colour runs) and format code 5 (256-colour runs) read a count byte and then a colour byte. The colour byte yields count pixels. Code 4 uses only the low nibble of the colour byte as the index.
- R4: A count of zero fills the rest of the current line (of LINE_W pixels) with index 0. If the count arrives at column 0, nothing is emitted.
- R5: In a bitmap format with `warp_en` set, a byte equal to `warp_code` at a byte boundary is followed by a count byte and a colour byte (the full byte is the index). These three bytes act as a run. With `warp_en` clear, that byte is ordinary pixel data.
- R6: The output is (a*p + (15-a)*v)/15, truncated. Here a and p are the palette opacity and value of the index, and v is the paired video pixel. a=15 gives p and a=0 gives v.
- R7: When format code 0 is selected and `outline_en` is set, an index-0 pixel next to an index-1 pixel on the same line is output as `outline_color` at full opacity. Neighbours on another line do not count, and no outline appears in other formats.
- R8: Each video pixel accepted (`vid_valid` and `vid_ready`) produces one output, one cycle later and in order. `vid_ready` stays low while no decoded pixel is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 3 | Source format code |
| warp_en | input | 1 | Enables warp run codes in bitmap formats |
| warp_code | input | 8 | Byte value that introduces a warp run |
| outline_en | input | 1 | Enables outline generation in 1-bit format |
| outline_color | input | VAL_W | Value used for outline pixels |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 8 | Palette write index |
| pal_alpha | input | 4 | Opacity written to the palette entry |
| pal_value | input | VAL_W | Pixel value written to the palette entry |
| in_valid | input | 1 | Source byte available |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Source byte accepted when high with in_valid |
| vid_valid | input | 1 | Video pixel available |
| vid_data | input | VAL_W | Video pixel |
| vid_ready | output | 1 | Video pixel accepted when high with vid_valid |
| out_valid | output | 1 | Mixed pixel valid |
| out_data | output | VAL_W | Mixed pixel |

## Verification
The hardest case to reach is the outline decision at a line boundary. A transparent pixel at the end of one line must not take an outline from a foreground pixel at the start of the next line. At that moment the right-hand neighbour is already sitting in the lookahead slot. The stimulus uses a four-pixel line and 1-bit bytes chosen so that a background pixel in the last column is followed directly in the stream by a foreground pixel in column 0. The pixel after that foreground pixel must then receive an outline. A zero count arriving at column 0 is also hard to reach. It is forced by sending two zero counts back to back, so that the first zero count pads the line and the second one arrives at column 0.

// File: rtl/osd_pkg.sv
package osd_pkg;

    localparam logic [2:0] FMT_BM1   = 3'd0;
    localparam logic [2:0] FMT_BM2   = 3'd1;
    localparam logic [2:0] FMT_BM4   = 3'd2;
    localparam logic [2:0] FMT_BM8   = 3'd3;
    localparam logic [2:0] FMT_RL16  = 3'd4;
    localparam logic [2:0] FMT_RL256 = 3'd5;

    typedef struct packed {
        logic [7:0] idx;
        logic       first;
        logic       last;
    } pix_t;

endpackage

// File: rtl/osd_unpack.sv
module osd_unpack
    import osd_pkg::*;
#(
    parameter int LINE_W = 720
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] fmt,
    input  logic       warp_en,
    input  logic [7:0] warp_code,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       gen_valid,
    output pix_t       gen_pix,
    input  logic       gen_ready
);

    localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam logic [CW-1:0] LAST_COL = CW'(LINE_W - 1);

    typedef enum logic [2:0] {G_BYTE, G_WCNT, G_IDX, G_BITS, G_RUN, G_PAD} gst_e;

    gst_e          state, state_nx;
    logic [7:0]    sh;
    logic [3:0]    left;
    logic [7:0]    run_cnt;
    logic [7:0]    run_idx;
    logic [CW-1:0] col;

    logic       is_rl, take, push, at_last;
    logic [7:0] bm_idx;
    logic [3:0] per_byte;
    logic [3:0] bpp;

    assign is_rl   = (fmt == FMT_RL16) || (fmt == FMT_RL256);
    assign at_last = (col == LAST_COL);
    assign take    = in_valid && in_ready;
    assign push    = gen_valid && gen_ready;
    assign bpp     = 4'd1 << fmt[1:0];

    always_comb begin
        unique case (fmt[1:0])
            2'd0:    begin bm_idx = {7'b0, sh[7]};   per_byte = 4'd8; end
            2'd1:    begin bm_idx = {6'b0, sh[7:6]}; per_byte = 4'd4; end
            2'd2:    begin bm_idx = {4'b0, sh[7:4]}; per_byte = 4'd2; end
            default: begin bm_idx = sh;              per_byte = 4'd1; end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= G_BYTE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            G_BYTE: if (take) begin
                if (is_rl) begin
                    if (in_data != 8'd0)  state_nx = G_IDX;
                    else if (col != '0)   state_nx = G_PAD;
                end else if (warp_en && in_data == warp_code) begin
                    state_nx = G_WCNT;
                end else begin
                    state_nx = G_BITS;
                end
            end
            G_WCNT: if (take) begin
                if (in_data != 8'd0)      state_nx = G_IDX;
                else if (col != '0)       state_nx = G_PAD;
                else                      state_nx = G_BYTE;
            end
            G_IDX:  if (take) state_nx = G_RUN;
            G_BITS: if (push && left == 4'd1)    state_nx = G_BYTE;
            G_RUN:  if (push && run_cnt == 8'd1) state_nx = G_BYTE;
            G_PAD:  if (push && at_last)         state_nx = G_BYTE;
            default: state_nx = G_BYTE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        gen_valid = 1'b0;
        gen_pix   = '{idx: 8'd0, first: (col == '0), last: at_last};
        unique case (state)
            G_BYTE, G_WCNT, G_IDX: in_ready = 1'b1;
            G_BITS: begin gen_valid = 1'b1; gen_pix.idx = bm_idx;  end
            G_RUN:  begin gen_valid = 1'b1; gen_pix.idx = run_idx; end
            G_PAD:  begin gen_valid = 1'b1; gen_pix.idx = 8'd0;    end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            left    <= '0;
            run_cnt <= '0;
            run_idx <= '0;
            col     <= '0;
        end else begin
            if (take && (state == G_BYTE) && !is_rl) begin
                sh   <= in_data;
                left <= per_byte;
            end
            if (take && (state == G_WCNT || (state == G_BYTE && is_rl)))
                run_cnt <= in_data;
            if (take && state == G_IDX)
                run_idx <= (fmt == FMT_RL16) ? {4'b0, in_data[3:0]} : in_data;
            if (push && state == G_BITS) begin
                sh   <= sh << bpp;
                left <= left - 4'd1;
            end
            if (push && state == G_RUN)
                run_cnt <= run_cnt - 8'd1;
            if (push)
                col <= at_last ? '0 : col + 1'b1;
        end
    end

    a_r2_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && gen_pix.last) |=> (col == '0));
    a_r4_pad_ends_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_PAD && push && gen_pix.last) |=> (state == G_BYTE));
    a_r3_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_RUN) |-> (run_cnt != 8'd0));

endmodule

// File: rtl/osd_window.sv
module osd_window
    import osd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       outline_on,
    input  logic       gen_valid,
    input  pix_t       gen_pix,
    output logic       gen_ready,
    input  logic       vid_valid,
    output logic       vid_ready,
    output logic       emit,
    output logic [7:0] cur_idx,
    output logic       cur_outline
);

    pix_t       q0, q1;
    logic [1:0] cnt;
    logic       left_fg;
    logic       push;

    assign vid_ready = (cnt != 2'd0) && (cnt == 2'd2 || q0.last);
    assign emit      = vid_ready && vid_valid;
    assign gen_ready = (cnt != 2'd2) || emit;
    assign push      = gen_valid && gen_ready;
    assign cur_idx   = q0.idx;

    always_comb begin
        cur_outline = outline_on && (q0.idx == 8'd0) &&
                      (left_fg || (cnt == 2'd2 && !q0.last && q1.idx == 8'd1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0      <= '0;
            q1      <= '0;
            cnt     <= '0;
            left_fg <= 1'b0;
        end else begin
            unique case ({push, emit})
                2'b10: begin
                    if (cnt == 2'd0) q0 <= gen_pix;
                    else             q1 <= gen_pix;
                    cnt <= cnt + 2'd1;
                end
                2'b01: begin
                    q0  <= q1;
                    cnt <= cnt - 2'd1;
                end
                2'b11: begin
                    if (cnt == 2'd1) q0 <= gen_pix;
                    else begin
                        q0 <= q1;
                        q1 <= gen_pix;
                    end
                end
                default: ;
            endcase
            if (emit) left_fg <= (q0.idx == 8'd1) && !q0.last;
        end
    end

    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);
    a_r8_video_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd0) |-> !vid_ready);

endmodule

// File: rtl/osd_blend.sv
module osd_blend #(
    parameter int PAL_DEPTH = 256,
    parameter int VAL_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_we,
    input  logic [7:0]       pal_addr,
    input  logic [3:0]       pal_alpha,
    input  logic [VAL_W-1:0] pal_value,
    input  logic             emit,
    input  logic [7:0]       idx,
    input  logic             outline,
    input  logic [VAL_W-1:0] outline_color,
    input  logic [VAL_W-1:0] vid_data,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_data
);

    localparam int AW = (PAL_DEPTH > 1) ? $clog2(PAL_DEPTH) : 1;
    localparam int MW = VAL_W + 4;

    logic [3:0]       alpha_mem [PAL_DEPTH];
    logic [VAL_W-1:0] val_mem   [PAL_DEPTH];

    logic [3:0]       sel_a;
    logic [VAL_W-1:0] sel_v;
    logic [MW-1:0]    mix, quo;

    always_ff @(posedge clk) begin
        if (pal_we) begin
            alpha_mem[pal_addr[AW-1:0]] <= pal_alpha;
            val_mem[pal_addr[AW-1:0]]   <= pal_value;
        end
    end

    always_comb begin
        if (outline) begin
            sel_a = 4'd15;
            sel_v = outline_color;
        end else begin
            sel_a = alpha_mem[idx[AW-1:0]];
            sel_v = val_mem[idx[AW-1:0]];
        end
        mix = MW'(sel_a) * MW'(sel_v) + MW'(4'd15 - sel_a) * MW'(vid_data);
        quo = mix / MW'(15);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_data <= quo[VAL_W-1:0];
        end
    end

    a_r6_opaque_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && sel_a == 4'd15) |=> (out_data == $past(sel_v)));
    a_r6_clear_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && sel_a == 4'd0) |=> (out_data == $past(vid_data)));

endmodule

// File: rtl/osd_pixel_decoder.sv
module osd_pixel_decoder
    import osd_pkg::*;
#(
    parameter int LINE_W    = 720,
    parameter int PAL_DEPTH = 256,
    parameter int VAL_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fmt,
    input  logic             warp_en,
    input  logic [7:0]       warp_code,
    input  logic             outline_en,
    input  logic [VAL_W-1:0] outline_color,
    input  logic             pal_we,
    input  logic [7:0]       pal_addr,
    input  logic [3:0]       pal_alpha,
    input  logic [VAL_W-1:0] pal_value,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             vid_valid,
    input  logic [VAL_W-1:0] vid_data,
    output logic             vid_ready,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_data
);

    pix_t       gen_pix;
    logic       gen_valid, gen_ready;
    logic       emit, cur_outline, outline_on;
    logic [7:0] cur_idx;

    assign outline_on = outline_en && (fmt == FMT_BM1);

    osd_unpack #(.LINE_W(LINE_W)) unpack_i (
        .clk, .rst_n, .fmt, .warp_en, .warp_code,
        .in_valid, .in_data, .in_ready,
        .gen_valid, .gen_pix, .gen_ready
    );

    osd_window window_i (
        .clk, .rst_n, .outline_on,
        .gen_valid, .gen_pix, .gen_ready,
        .vid_valid, .vid_ready, .emit, .cur_idx, .cur_outline
    );

    osd_blend #(.PAL_DEPTH(PAL_DEPTH), .VAL_W(VAL_W)) blend_i (
        .clk, .rst_n, .pal_we, .pal_addr, .pal_alpha, .pal_value,
        .emit, .idx(cur_idx), .outline(cur_outline), .outline_color,
        .vid_data, .out_valid, .out_data
    );

    a_r7_outline_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cur_outline |-> (fmt == FMT_BM1 && outline_en && cur_idx == 8'd0));
    a_r8_one_out_per_video: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_valid && vid_ready) |=> out_valid);

endmodule

// File: tb/osd_pixel_decoder_tb_top.sv
module osd_pixel_decoder_tb_top;

    localparam int LW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fmt = 3'd0;
    logic       warp_en = 1'b0;
    logic [7:0] warp_code = 8'd0;
    logic       outline_en = 1'b0;
    logic [7:0] outline_color = 8'hF0;
    logic       pal_we = 1'b0;
    logic [7:0] pal_addr = 8'd0;
    logic [3:0] pal_alpha = 4'd0;
    logic [7:0] pal_value = 8'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_ready;
    logic       vid_valid = 1'b0;
    logic [7:0] vid_data;
    logic       vid_ready;
    logic       out_valid;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    osd_pixel_decoder #(.LINE_W(LW)) dut_i (
        .clk, .rst_n, .fmt, .warp_en, .warp_code, .outline_en, .outline_color,
        .pal_we, .pal_addr, .pal_alpha, .pal_value,
        .in_valid, .in_data, .in_ready,
        .vid_valid, .vid_data, .vid_ready, .out_valid, .out_data
    );

    int checks = 0;
    int fails  = 0;

    int    pa [256];
    int    pv [256];
    int    ea [256];
    int    ev [256];
    string et [256];
    int    ne = 0;
    int    ng = 0;
    int    nacc = 0;

    function automatic int vidpat(int n);
        return (n * 37 + 11) & 255;
    endfunction

    function automatic int mixf(int a, int p, int v);
        return (a * p + (15 - a) * v) / 15;
    endfunction

    assign vid_data = 8'(vidpat(nacc));

    always @(posedge clk)
        if (!rst_n) nacc <= 0;
        else if (vid_valid && vid_ready) nacc <= nacc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (ng >= ne) chk(1'b0, "R8 unexpected output", int'(out_data), -1);
            else chk(int'(out_data) == mixf(ea[ng], ev[ng], vidpat(ng)),
                     et[ng], int'(out_data), mixf(ea[ng], ev[ng], vidpat(ng)));
            ng++;
        end
    end

    task automatic wr_pal(input int a, input int al, input int v);
        @(negedge clk);
        pal_we = 1'b1; pal_addr = 8'(a); pal_alpha = 4'(al); pal_value = 8'(v);
        @(negedge clk);
        pal_we = 1'b0;
        pa[a] = al; pv[a] = v;
    endtask

    task automatic exp_idx(input int i, input string tag);
        ea[ne] = pa[i]; ev[ne] = pv[i]; et[ne] = tag; ne++;
    endtask

    task automatic exp_ol(input string tag);
        ea[ne] = 15; ev[ne] = int'(outline_color); et[ne] = tag; ne++;
    endtask

    task automatic push(input int b);
        in_valid = 1'b1; in_data = 8'(b);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (ng < ne && t < 2000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        chk(ng == ne, tag, ng, ne);
    endtask

    // blend vectors: {alpha, value}
    localparam int BT [8][2] = '{
        '{15, 200}, '{0, 200}, '{7, 100}, '{8, 255},
        '{15, 0},   '{1, 250}, '{14, 3},  '{10, 128}
    };

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(vid_ready == 1'b0, "R1 vid_ready", int'(vid_ready), 0);

        for (int i = 0; i < 256; i++) wr_pal(i, 15, (i * 7 + 3) & 255);
        vid_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R8: no decoded pixel, no video taken, no output
        chk(vid_ready == 1'b0 && ng == 0, "R8 idle", ng, 0);

        // R6 blend table walked in 8-bit bitmap format (R2)
        fmt = 3'd3;
        foreach (BT[i]) wr_pal(16 + i, BT[i][0], BT[i][1]);
        foreach (BT[i]) exp_idx(16 + i, "R6 blend vector");
        foreach (BT[i]) push(16 + i);
        drain("R8 count after blend table");

        // R2 1-bit: 1011_0000
        fmt = 3'd0;
        exp_idx(1, "R2 bm1"); exp_idx(0, "R2 bm1"); exp_idx(1, "R2 bm1"); exp_idx(1, "R2 bm1");
        for (int k = 0; k < 4; k++) exp_idx(0, "R2 bm1");
        push(8'b1011_0000);
        drain("R2 bm1 count");

        // R2 2-bit: 11_01_10_00
        fmt = 3'd1;
        exp_idx(3, "R2 bm2"); exp_idx(1, "R2 bm2"); exp_idx(2, "R2 bm2"); exp_idx(0, "R2 bm2");
        push(8'b1101_1000);
        drain("R2 bm2 count");

        // R2 4-bit: 0x5A 0x3C
        fmt = 3'd2;
        exp_idx(5, "R2 bm4"); exp_idx(10, "R2 bm4"); exp_idx(3, "R2 bm4"); exp_idx(12, "R2 bm4");
        push(8'h5A); push(8'h3C);
        drain("R2 bm4 count");

        // R3 16-colour runs: low nibble only
        fmt = 3'd4;
        for (int k = 0; k < 3; k++) exp_idx(7, "R3 rl16 nibble");
        exp_idx(2, "R3 rl16");
        push(3); push(8'h17); push(1); push(8'h02);
        drain("R3 rl16 count");

        // R3 256-colour runs, R4 zero count mid-line and at column 0
        fmt = 3'd5;
        exp_idx(8'hC8, "R3 rl256"); exp_idx(8'hC8, "R3 rl256");
        exp_idx(0, "R4 pad"); exp_idx(0, "R4 pad");
        for (int k = 0; k < 4; k++) exp_idx(8'h21, "R4 after col0 zero");
        push(2); push(8'hC8); push(0); push(0); push(4); push(8'h21);
        drain("R4 count");

        // R5 warp on in 4-bit format
        fmt = 3'd2; warp_en = 1'b1; warp_code = 8'hEE;
        exp_idx(1, "R5 warp"); exp_idx(2, "R5 warp");
        for (int k = 0; k < 4; k++) exp_idx(8'h33, "R5 warp run");
        exp_idx(4, "R5 warp"); exp_idx(5, "R5 warp");
        push(8'h12); push(8'hEE); push(4); push(8'h33); push(8'h45);
        drain("R5 warp count");

        // R5 warp off: code byte is plain pixels
        warp_en = 1'b0;
        exp_idx(1, "R5 warp off"); exp_idx(2, "R5 warp off");
        exp_idx(14, "R5 warp off"); exp_idx(14, "R5 warp off");
        push(8'h12); push(8'hEE);
        drain("R5 warp off count");

        // R7 outline in 1-bit format, line boundary isolation
        wr_pal(0, 0, 0);
        fmt = 3'd0; outline_en = 1'b1;
        exp_ol("R7 outline right nb"); exp_idx(1, "R7 fg"); exp_idx(1, "R7 fg"); exp_ol("R7 outline left nb");
        for (int k = 0; k < 4; k++) exp_idx(0, "R7 no cross-line outline");
        exp_idx(1, "R7 fg"); exp_ol("R7 outline after line start");
        exp_idx(0, "R7 bg"); exp_idx(0, "R7 bg");
        for (int k = 0; k < 4; k++) exp_idx(0, "R7 bg");
        push(8'b0110_0000); push(8'b1000_0000);
        drain("R7 outline count");

        // R7 no outline in 2-bit format
        fmt = 3'd1;
        exp_idx(0, "R7 none in bm2"); exp_idx(1, "R7 none in bm2");
        exp_idx(0, "R7 none in bm2"); exp_idx(0, "R7 none in bm2");
        push(8'b0001_0000);
        drain("R7 bm2 count");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule